// File: doc/BRIEF.md
# External Interrupt Request Detector

This block watches six external interrupt request pins and turns them into one prioritised request for a CPU-side comparator. Each pin is first brought into the clock domain by a two-flop synchroniser. A per-pin sense setting then picks one of four detection modes: falling edge, rising edge, active-low level or active-high level. Edge events are latched into a request bit. Software clears that bit with a handshake: it must first read the bit back as 1 and then write 0 to it. A level request is never stored. It simply follows the synchronised pin.

Every pin carries a 4-bit priority. Priority 0 disables the pin. The block reports the highest pending priority and the pin that owns it, and it raises its interrupt output when that priority is strictly greater than a 4-bit mask supplied by the CPU. Rewriting a pin's sense mode can latch a request from the pin's present level. This spurious request is removed through the same read-1/write-0 handshake.

Software reaches the settings through a small register port. The read data is combinational from the address. The read strobe is used only to arm the clear handshake.

Top module: `ext_irq_detector`

## Requirements
- R1: After reset, every request bit, every sense field and every priority field is 0, and `irq_o`, `prio_o` and `src_o` are all 0.
- R2: Register map, 16-bit data:
  - Address 0 holds the sense setting of pin i in bits 2i+1:2i. The upper bit selects level mode (1) or edge mode (0). The lower bit selects high/rising (1) or low/falling (0).
  - Address 1 holds the priorities of pins 0..2, and address 2 holds those of pins 3..5. Pin k of each group sits at bits 4k+3:4k.
  - Address 3 reads the six request bits in bits 5:0.
  - Unused bits read 0. Written settings read back unchanged.
- R3: In edge mode, a transition of the pin to the level that the polarity bit names latches the pin's request bit, provided the new level is held for at least three clock cycles.
- R4: A latched edge request stays set after the pin returns to its idle level, and further activity on the pin does not remove it.
- R5: A write of 0 to request bit i at address 3 clears the latch only if bit i was read as 1 with the read strobe since the previous write to address 3. Writing 1, or writing 0 without that read, leaves the bit unchanged. Every write to address 3 disarms all bits.
- R6: In level mode, the request bit equals (synchronised pin == polarity bit). It is never latched, and writes to address 3 do not affect it.
- R7: Changing a pin's sense field to an edge mode while the pin already sits at that mode's active level latches a request. Changing the field to a level mode drops any latched request. The handshake of R5 clears a spurious request.
- R8: A pin whose priority is 0 never contributes to `prio_o`, `src_o` or `irq_o`.
- R9: `prio_o` is the largest priority among pending pins, and `src_o` is the lowest-numbered pending pin that holds it. Both are 0 when nothing is pending.
- R10: `irq_o` is 1 exactly when `prio_o` is strictly greater than `mask_i`. The block never changes the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pin_i | input | 6 | Raw external request pins |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (arms the clear handshake) |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data, combinational from address |
| mask_i | input | 4 | CPU interrupt mask level |
| irq_o | output | 1 | Pending priority exceeds mask |
| prio_o | output | 4 | Highest pending priority |
| src_o | output | 3 | Pin owning the highest pending priority |

## Verification
The bench tries a write of 0 with no prior read of 1, and a write of 1 after a read. A design that clears on any write of 0 would lose that request, and one that treats the data bit the wrong way round would drop a bit software asked to keep. Sense rewrites are made while a pin sits at its active level, to check the spurious latch and its removal. A design that ignores the rewrite would miss a request that software must clear, and one that latches unconditionally would invent requests. Equal priorities on two pins, a zero priority and a mask equal to the winner are all driven, so a wrong tie order, a disabled pin that still wins, or a non-strict compare show up on `src_o` and `irq_o`. Three-cycle pulses and random pin, sense, priority and mask activity cover the detector and the select against a bench model.

// File: rtl/irq_det_pkg.sv
package irq_det_pkg;

  typedef enum logic [1:0] {
    ADR_SENSE   = 2'd0,
    ADR_PRIO_LO = 2'd1,
    ADR_PRIO_HI = 2'd2,
    ADR_REQ     = 2'd3
  } reg_addr_e;

  // level: 1 = level mode, 0 = edge mode; pol: 1 = high/rising, 0 = low/falling
  typedef struct packed {
    logic level;
    logic pol;
  } sense_cfg_t;

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned WIDTH  = 6,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= d_i;
      end
    end else begin : g_rest
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/irq_sense_cell.sv
module irq_sense_cell
  import irq_det_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pin_s_i,    // synchronised pin
  input  sense_cfg_t cfg_i,      // current sense setting
  input  sense_cfg_t cfg_nxt_i,  // setting being written
  input  logic       cfg_chg_i,  // setting changes at this edge
  input  logic       clr_i,      // armed clear from handshake
  output logic       req_o
);

  logic prev_q;
  logic latch_q, latch_d;
  logic hit;

  assign hit = !cfg_i.level && (pin_s_i != prev_q) && (pin_s_i == cfg_i.pol);

  always_comb begin
    latch_d = latch_q;
    if (clr_i) latch_d = 1'b0;
    if (hit)   latch_d = 1'b1;
    if (cfg_chg_i) begin
      if (cfg_nxt_i.level) latch_d = 1'b0;
      else                 latch_d = latch_d | (pin_s_i == cfg_nxt_i.pol);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      prev_q  <= pin_s_i;
      latch_q <= latch_d;
    end
  end

  assign req_o = cfg_i.level ? (pin_s_i == cfg_i.pol) : latch_q;

  p_edge_latch_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && !cfg_chg_i) |=> latch_q);

  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latch_q && !clr_i && !cfg_chg_i) |=> latch_q);

  p_fall_cause_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(latch_q) |-> $past(clr_i || cfg_chg_i));

  p_level_unlatched_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_i.level |-> !latch_q);

endmodule

// File: rtl/irq_prio_select.sv
module irq_prio_select #(
  parameter int unsigned NUM_PINS = 6,
  parameter int unsigned PRIO_W   = 4,
  parameter int unsigned SRC_W    = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_PINS-1:0] req_i,
  input  logic [PRIO_W-1:0] prio_i [NUM_PINS],
  output logic [PRIO_W-1:0] best_prio_o,
  output logic [SRC_W-1:0]  best_src_o
);

  // scan from the top index down; ">=" lets lower indices win ties
  always_comb begin
    best_prio_o = '0;
    best_src_o  = '0;
    for (int i = NUM_PINS - 1; i >= 0; i--) begin
      if (req_i[i] && (prio_i[i] != '0) && (prio_i[i] >= best_prio_o)) begin
        best_prio_o = prio_i[i];
        best_src_o  = SRC_W'(i);
      end
    end
  end

  p_winner_pending_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (best_prio_o != '0) |-> (req_i[best_src_o] && prio_i[best_src_o] == best_prio_o));

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_chk
    p_not_beaten_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i[g] && prio_i[g] != '0) |-> (best_prio_o >= prio_i[g]));
  end

endmodule

// File: rtl/ext_irq_detector.sv
module ext_irq_detector
  import irq_det_pkg::*;
#(
  parameter int unsigned NUM_PINS = 6,
  parameter int unsigned PRIO_W   = 4,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned SYNC_STG = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic [PRIO_W-1:0] mask_i,
  output logic              irq_o,
  output logic [PRIO_W-1:0] prio_o,
  output logic [2:0]        src_o
);

  localparam int unsigned PER_BANK = (NUM_PINS + 1) / 2;
  localparam int unsigned SRC_W    = 3;

  reg_addr_e adr;
  assign adr = reg_addr_e'(reg_addr_i);

  sense_cfg_t          cfg_q  [NUM_PINS];
  sense_cfg_t          cfg_d  [NUM_PINS];
  logic [PRIO_W-1:0]   prio_q [NUM_PINS];
  logic [PRIO_W-1:0]   prio_d [NUM_PINS];
  logic [NUM_PINS-1:0] arm_q, arm_d;
  logic [NUM_PINS-1:0] cfg_chg, clr, req, pin_s;
  logic                cfg_en, prio_en, arm_en;
  logic                prio_bank;

  irq_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STG)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_s)
  );

  // next-state for the register file
  always_comb begin
    cfg_d     = cfg_q;
    prio_d    = prio_q;
    arm_d     = arm_q;
    cfg_chg   = '0;
    clr       = '0;
    cfg_en    = 1'b0;
    prio_en   = 1'b0;
    arm_en    = 1'b0;
    prio_bank = (adr == ADR_PRIO_HI);
    if (reg_wr_i) begin
      unique case (adr)
        ADR_SENSE: begin
          cfg_en = 1'b1;
          for (int i = 0; i < NUM_PINS; i++) begin
            cfg_d[i]   = sense_cfg_t'(reg_wdata_i[2*i +: 2]);
            cfg_chg[i] = (cfg_d[i] != cfg_q[i]);
          end
        end
        ADR_PRIO_LO, ADR_PRIO_HI: begin
          prio_en = 1'b1;
          for (int i = 0; i < NUM_PINS; i++) begin
            if ((i / PER_BANK) == int'(prio_bank))
              prio_d[i] = reg_wdata_i[(i % PER_BANK)*PRIO_W +: PRIO_W];
          end
        end
        ADR_REQ: begin
          arm_en = 1'b1;
          clr    = arm_q & ~reg_wdata_i[NUM_PINS-1:0];
          arm_d  = '0;
        end
        default: ;
      endcase
    end else if (reg_rd_i && adr == ADR_REQ) begin
      arm_en = 1'b1;
      arm_d  = arm_q | req;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_PINS; i++) begin
        cfg_q[i]  <= '0;
        prio_q[i] <= '0;
      end
      arm_q <= '0;
    end else begin
      if (cfg_en)  cfg_q  <= cfg_d;
      if (prio_en) prio_q <= prio_d;
      if (arm_en)  arm_q  <= arm_d;
    end
  end

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_cell
    irq_sense_cell u_cell (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .pin_s_i  (pin_s[g]),
      .cfg_i    (cfg_q[g]),
      .cfg_nxt_i(cfg_d[g]),
      .cfg_chg_i(cfg_chg[g]),
      .clr_i    (clr[g]),
      .req_o    (req[g])
    );
  end

  irq_prio_select #(.NUM_PINS(NUM_PINS), .PRIO_W(PRIO_W), .SRC_W(SRC_W)) u_sel (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req),
    .prio_i     (prio_q),
    .best_prio_o(prio_o),
    .best_src_o (src_o)
  );

  assign irq_o = (prio_o > mask_i);

  // read path
  always_comb begin
    reg_rdata_o = '0;
    unique case (adr)
      ADR_SENSE:
        for (int i = 0; i < NUM_PINS; i++) reg_rdata_o[2*i +: 2] = cfg_q[i];
      ADR_PRIO_LO, ADR_PRIO_HI:
        for (int i = 0; i < NUM_PINS; i++) begin
          if ((i / PER_BANK) == int'(adr == ADR_PRIO_HI))
            reg_rdata_o[(i % PER_BANK)*PRIO_W +: PRIO_W] = prio_q[i];
        end
      ADR_REQ: reg_rdata_o[NUM_PINS-1:0] = req;
      default: ;
    endcase
  end

  p_arm_drop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && adr == ADR_REQ) |=> (arm_q == '0));

  p_irq_needs_pending_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (req != '0));

endmodule

// File: tb/test_ext_irq_detector.sv
module test_ext_irq_detector;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  pin;
  logic        wr, rd;
  logic [1:0]  addr;
  logic [15:0] wdata, rdata;
  logic [3:0]  mask;
  logic        irq;
  logic [3:0]  prio;
  logic [2:0]  src;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // bench model
  logic [1:0] m_cfg [6];
  logic [3:0] m_prio [6];
  logic [5:0] m_latch, m_arm, m_pin;

  always #10 clk = ~clk;

  ext_irq_detector i_ext_irq_detector (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .reg_wr_i(wr), .reg_rd_i(rd),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .mask_i(mask), .irq_o(irq), .prio_o(prio), .src_o(src)
  );

  function automatic logic [5:0] m_req();
    logic [5:0] r;
    for (int i = 0; i < 6; i++)
      r[i] = m_cfg[i][1] ? (m_pin[i] == m_cfg[i][0]) : m_latch[i];
    return r;
  endfunction

  function automatic logic [6:0] m_best();
    logic [5:0] r = m_req();
    logic [3:0] mx = 0;
    logic [2:0] s = 0;
    for (int i = 0; i < 6; i++) if (r[i] && m_prio[i] > mx) mx = m_prio[i];
    if (mx != 0)
      for (int i = 5; i >= 0; i--) if (r[i] && m_prio[i] == mx) s = 3'(i);
    return {mx, s};
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic peek(logic [1:0] a, output logic [15:0] v);
    @(negedge clk); addr = a; #1; v = rdata;
  endtask

  task automatic check_all(string tag);
    logic [15:0] v;
    logic [6:0] b = m_best();
    peek(2'd3, v);
    check({tag, " req"}, v, {10'd0, m_req()});
    check({tag, " prio"}, {12'd0, prio}, {12'd0, b[6:3]});
    check({tag, " src"}, {13'd0, src}, {13'd0, b[2:0]});
    check({tag, " irq R10"}, {15'd0, irq}, {15'd0, b[6:3] > mask});
  endtask

  task automatic reg_write(logic [1:0] a, logic [15:0] d);
    @(negedge clk); wr = 1; addr = a; wdata = d;
    @(negedge clk); wr = 0;
    case (a)
      2'd0: for (int i = 0; i < 6; i++) begin
        logic [1:0] n = d[2*i +: 2];
        if (n != m_cfg[i]) begin
          if (n[1]) m_latch[i] = 0;
          else if (m_pin[i] == n[0]) m_latch[i] = 1;
        end
        m_cfg[i] = n;
      end
      2'd1: for (int i = 0; i < 3; i++) m_prio[i] = d[4*i +: 4];
      2'd2: for (int i = 0; i < 3; i++) m_prio[3+i] = d[4*i +: 4];
      default: begin
        m_latch = m_latch & ~(m_arm & ~d[5:0]);
        m_arm = 0;
      end
    endcase
  endtask

  task automatic reg_read_arm();
    logic [15:0] v;
    @(negedge clk); rd = 1; addr = 2'd3; #1; v = rdata;
    @(negedge clk); rd = 0;
    m_arm = m_arm | v[5:0];
  endtask

  task automatic set_pins(logic [5:0] v);
    @(negedge clk); pin = v;
    for (int i = 0; i < 6; i++)
      if (!m_cfg[i][1] && v[i] != m_pin[i] && v[i] == m_cfg[i][0]) m_latch[i] = 1;
    m_pin = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse(int p, int width);
    logic [5:0] old = m_pin;
    logic [5:0] nv = m_pin ^ (6'd1 << p);
    @(negedge clk); pin = nv;
    for (int i = 0; i < 6; i++)
      if (!m_cfg[i][1] && nv[i] != old[i] && nv[i] == m_cfg[i][0]) m_latch[i] = 1;
    m_pin = nv;
    repeat (width - 1) @(negedge clk);
    set_pins(old);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    int unused_seed;
    unused_seed = $urandom(32'h5eed_1234);
    rst_n = 0; pin = 6'h3f; wr = 0; rd = 0; addr = 0; wdata = 0; mask = 0;
    for (int i = 0; i < 6; i++) begin m_cfg[i] = 0; m_prio[i] = 0; end
    m_latch = 0; m_arm = 0; m_pin = 6'h3f;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      peek(2'(a), v);
      check("R1 reg after reset", v, 16'h0);
    end
    check("R1 irq", {15'd0, irq}, 16'd0);
    check("R1 prio/src", {9'd0, prio, src}, 16'd0);

    // R2 register map readback
    reg_write(2'd1, 16'hF321);
    reg_write(2'd2, 16'hA654);
    peek(2'd1, v); check("R2 prio lo", v, 16'h0321);
    peek(2'd2, v); check("R2 prio hi", v, 16'h0654);
    reg_write(2'd0, 16'hF000);
    peek(2'd0, v); check("R2 sense", v, 16'h0000);

    // R3/R4 falling edge latch with 3-cycle pulse on pin 0
    reg_write(2'd1, 16'h0005); reg_write(2'd2, 16'h0000);
    pulse(0, 3);
    check_all("R3 edge latch");
    check("R3 bit0", {15'd0, m_latch[0]}, 16'd1);
    pulse(0, 5);
    check_all("R4 hold");

    // R5 clear handshake
    reg_write(2'd3, 16'h0000);
    check_all("R5 no arm write0");
    reg_read_arm();
    reg_write(2'd3, 16'h003f);
    check_all("R5 write1 after read");
    reg_write(2'd3, 16'h0000);
    check_all("R5 write0 disarmed");
    reg_read_arm();
    reg_write(2'd3, 16'h0000);
    check_all("R5 armed clear");
    peek(2'd3, v); check("R5 cleared", v, 16'h0);

    // R6 level low on pin 1 with priority 7
    reg_write(2'd1, 16'h0075);
    reg_write(2'd0, 16'h0008);
    set_pins(6'h3d);
    check_all("R6 level active");
    reg_read_arm(); reg_write(2'd3, 16'h0000);
    check_all("R6 write no effect");
    set_pins(6'h3f);
    check_all("R6 level released");

    // R7 spurious on sense change: pin 2 low, switch to falling edge
    reg_write(2'd1, 16'h0375);
    reg_write(2'd0, 16'h0028);
    set_pins(6'h3b);
    reg_write(2'd0, 16'h0008);
    check_all("R7 spurious set");
    reg_read_arm(); reg_write(2'd3, 16'h0000);
    check_all("R7 spurious cleared");
    set_pins(6'h3f);

    // R8 priority zero pin
    reg_write(2'd2, 16'h0000);
    pulse(3, 3);
    check_all("R8 zero prio");
    check("R8 irq", {15'd0, irq}, 16'd0);
    reg_read_arm(); reg_write(2'd3, 16'h0000);

    // R9 tie between pin 4 and pin 5 -> pin 4
    reg_write(2'd2, 16'h0990);
    pulse(5, 3); pulse(4, 3);
    check_all("R9 tie");
    check("R9 src", {13'd0, src}, 16'd4);

    // R10 strict compare
    mask = 4'd9; check_all("R10 mask equal");
    mask = 4'd8; check_all("R10 mask below");
    reg_read_arm(); reg_write(2'd3, 16'h0000);

    // random mix
    for (int it = 0; it < 400; it++) begin
      int op = $urandom_range(0, 5);
      case (op)
        0, 1: set_pins(6'($urandom));
        2: reg_write(2'd0, 16'($urandom) & 16'h0fff);
        3: reg_write(2'($urandom_range(1, 2)), 16'($urandom));
        4: begin reg_read_arm(); reg_write(2'd3, 16'($urandom)); end
        default: mask = 4'($urandom);
      endcase
      check_all("R9 random");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule